// File: doc/BRIEF.md
# Command Ring Controller with Data-Reference Fences

This block sits between a command producer and a command consumer. It holds a power-of-two ring of command entries, each made of a command word, a flag, and an optional tag that names one data block. The producer writes entries at a write pointer. The consumer takes them at a read pointer. Each pointer carries an extra wrap bit, so a full ring and an empty ring are told apart. While the ring is empty the consumer side shows no valid entry. While the ring is full the producer side is not ready.

A counter for each tag tracks how many entries in the ring still refer to that data block. A request to overwrite a data block is granted only when its counter is zero. A producer that wants to rewrite a block therefore waits until the consumer has retired the last command that uses it.

A drain input blocks all new pushes while it is held. A done output rises once the ring has emptied, which lets a readback proceed on a quiet ring.

Top module: `cmd_ring_ctrl`

## Requirements
- R1: After reset, the ring is empty: `pop_valid`=0, `push_ready`=1, `tag_busy`=0 and `drain_done`=0.
- R2: Commands come out at the pop port in the exact order in which they were pushed. Tag and flag stay with their command.
- R3: After DEPTH pushes with no pops, `push_ready` is 0. A `push_valid` held in that state stores nothing: exactly DEPTH entries are popped afterwards.
- R4: While the ring is empty, `pop_valid` is 0 and `pop_ready` has no effect. A command pushed afterwards is the next one popped.
- R5: Bit t of `tag_busy` is 1 exactly while at least one entry in the ring has `has_tag`=1 and tag t. It clears in the cycle after the last such entry is popped.
- R6: `data_wr_grant` is 1 only when `data_wr_req` is 1 and the tag on `data_wr_tag` has no pending entry. It is combinational in the current state.
- R7: Entries pushed with `push_has_tag`=0 never change `tag_busy`, whatever their `push_tag` value.
- R8: While `drain_req` is 1, `push_ready` is 0. `drain_done` is 1 exactly when `drain_req` is 1 and the ring is empty.
- R9: A push and a pop in the same cycle both take effect. The occupancy is unchanged, and a tag pushed and popped in that cycle keeps its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Producer offers an entry |
| push_ready | output | 1 | Ring accepts an entry this cycle |
| push_cmd | input | CMD_W | Command word |
| push_has_tag | input | 1 | Entry refers to a data block |
| push_tag | input | TAG_W | Data-block tag of the entry |
| pop_valid | output | 1 | Head entry is present |
| pop_ready | input | 1 | Consumer retires the head entry |
| pop_cmd | output | CMD_W | Head command word |
| pop_has_tag | output | 1 | Head entry refers to a data block |
| pop_tag | output | TAG_W | Head entry tag |
| data_wr_req | input | 1 | Producer wants to overwrite a data block |
| data_wr_tag | input | TAG_W | Tag of the block to overwrite |
| data_wr_grant | output | 1 | Overwrite permitted |
| tag_busy | output | NTAGS | Per-tag pending-reference flag |
| drain_req | input | 1 | Readback drain request |
| drain_done | output | 1 | Drain request met, ring empty |

## Verification
The assertions check three things on every cycle: that occupancy moves exactly by the push and pop handshakes, that neither overflow nor underflow can occur, and that the sum of the per-tag reference counts never exceeds the occupancy. They also check that a drain always blocks pushes and that a grant only answers a request. Only the scenarios can show that commands come out in push order, that the fence releases in the right cycle after the last tagged pop, and that untagged entries leave the fences alone. The same holds for a push and a pop on the same tag in one cycle, which must keep the count.

// File: rtl/cmd_ring_ctrl.sv
module cmd_ring_ctrl #(
  parameter int DEPTH = 16,
  parameter int CMD_W = 32,
  parameter int NTAGS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_valid,
  output logic                       push_ready,
  input  logic [CMD_W-1:0]           push_cmd,
  input  logic                       push_has_tag,
  input  logic [$clog2(NTAGS)-1:0]   push_tag,
  output logic                       pop_valid,
  input  logic                       pop_ready,
  output logic [CMD_W-1:0]           pop_cmd,
  output logic                       pop_has_tag,
  output logic [$clog2(NTAGS)-1:0]   pop_tag,
  input  logic                       data_wr_req,
  input  logic [$clog2(NTAGS)-1:0]   data_wr_tag,
  output logic                       data_wr_grant,
  output logic [NTAGS-1:0]           tag_busy,
  input  logic                       drain_req,
  output logic                       drain_done
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int TAG_W = $clog2(NTAGS);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int SUM_W = CNT_W + TAG_W + 1;

  logic [CMD_W-1:0] mem_cmd [DEPTH];
  logic             mem_has [DEPTH];
  logic [TAG_W-1:0] mem_tag [DEPTH];

  logic [PTR_W:0] wptr, rptr;
  logic [PTR_W:0] occ;
  logic           empty, full, push_fire, pop_fire;
  logic [CNT_W-1:0] ref_cnt [NTAGS];

  assign occ   = wptr - rptr;
  assign empty = (wptr == rptr);
  assign full  = (wptr[PTR_W-1:0] == rptr[PTR_W-1:0]) && (wptr[PTR_W] != rptr[PTR_W]);

  assign push_ready = !full && !drain_req;
  assign pop_valid  = !empty;
  assign push_fire  = push_valid && push_ready;
  assign pop_fire   = pop_valid && pop_ready;

  assign pop_cmd     = mem_cmd[rptr[PTR_W-1:0]];
  assign pop_has_tag = mem_has[rptr[PTR_W-1:0]];
  assign pop_tag     = mem_tag[rptr[PTR_W-1:0]];

  assign drain_done    = drain_req && empty;
  assign data_wr_grant = data_wr_req && (ref_cnt[data_wr_tag] == '0);

  always_ff @(posedge clk) begin
    if (push_fire) begin
      mem_cmd[wptr[PTR_W-1:0]] <= push_cmd;
      mem_has[wptr[PTR_W-1:0]] <= push_has_tag;
      mem_tag[wptr[PTR_W-1:0]] <= push_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push_fire) wptr <= wptr + 1'b1;
      if (pop_fire)  rptr <= rptr + 1'b1;
    end
  end

  for (genvar t = 0; t < NTAGS; t++) begin : g_tag
    logic inc, dec;
    assign inc = push_fire && push_has_tag && (push_tag == TAG_W'(t));
    assign dec = pop_fire && pop_has_tag && (pop_tag == TAG_W'(t));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ref_cnt[t] <= '0;
      else if (inc && !dec) ref_cnt[t] <= ref_cnt[t] + 1'b1;
      else if (dec && !inc) ref_cnt[t] <= ref_cnt[t] - 1'b1;
    end
    assign tag_busy[t] = (ref_cnt[t] != '0);
  end

  logic [SUM_W-1:0] ref_total;
  always_comb begin
    ref_total = '0;
    for (int i = 0; i < NTAGS; i++) ref_total = ref_total + SUM_W'(ref_cnt[i]);
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |-> (occ < (PTR_W+1)'(DEPTH)));
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !pop_valid);
  p_occ_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire || pop_fire) |=>
      (occ == $past(occ) + (PTR_W+1)'($past(push_fire)) - (PTR_W+1)'($past(pop_fire))));
  p_refs_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_total <= SUM_W'(occ));
  p_grant_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_grant |-> (data_wr_req && !tag_busy[data_wr_tag]));
  p_drain_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req |-> !push_ready);
  p_drain_done_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> !pop_valid);
endmodule

// File: tb/cmd_ring_ctrl_bench.sv
module cmd_ring_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CMD_W = 32;
  localparam int NTAGS = 8;
  localparam int TAG_W = $clog2(NTAGS);

  logic clk = 0, rst_n = 0;
  logic push_valid = 0, push_has_tag = 0, pop_ready = 0, data_wr_req = 0, drain_req = 0;
  logic [CMD_W-1:0] push_cmd = '0;
  logic [TAG_W-1:0] push_tag = '0, data_wr_tag = '0;
  logic push_ready, pop_valid, pop_has_tag, data_wr_grant, drain_done;
  logic [CMD_W-1:0] pop_cmd;
  logic [TAG_W-1:0] pop_tag;
  logic [NTAGS-1:0] tag_busy;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_ring_ctrl #(.DEPTH(DEPTH), .CMD_W(CMD_W), .NTAGS(NTAGS)) u_cmd_ring_ctrl (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_ready(push_ready), .push_cmd(push_cmd),
    .push_has_tag(push_has_tag), .push_tag(push_tag),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_cmd(pop_cmd),
    .pop_has_tag(pop_has_tag), .pop_tag(pop_tag),
    .data_wr_req(data_wr_req), .data_wr_tag(data_wr_tag), .data_wr_grant(data_wr_grant),
    .tag_busy(tag_busy), .drain_req(drain_req), .drain_done(drain_done));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push_one(logic [CMD_W-1:0] c, logic h, logic [TAG_W-1:0] t);
    push_valid = 1; push_cmd = c; push_has_tag = h; push_tag = t;
    step();
    push_valid = 0; push_has_tag = 0;
  endtask

  task automatic pop_one(string req, logic [CMD_W-1:0] c);
    check(req, {63'd0, pop_valid}, 64'd1);
    check(req, pop_cmd, c);
    pop_ready = 1;
    step();
    pop_ready = 0;
  endtask

  task automatic t_reset();
    check("R1", {63'd0, pop_valid}, 0);
    check("R1", {63'd0, push_ready}, 1);
    check("R1", tag_busy, 0);
    check("R1", {63'd0, drain_done}, 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) push_one(32'hA000 + i, 0, 0);
    for (int i = 0; i < 5; i++) pop_one("R2", 32'hA000 + i);
    check("R2", {63'd0, pop_valid}, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) push_one(32'hB000 + i, 0, 0);
    check("R3", {63'd0, push_ready}, 0);
    push_valid = 1; push_cmd = 32'hDEAD;
    step(); step();
    push_valid = 0;
    for (int i = 0; i < DEPTH; i++) pop_one("R3", 32'hB000 + i);
    check("R3", {63'd0, pop_valid}, 0);
  endtask

  task automatic t_empty();
    pop_ready = 1; step(); step(); pop_ready = 0;
    check("R4", {63'd0, pop_valid}, 0);
    push_one(32'hC001, 0, 0);
    pop_one("R4", 32'hC001);
  endtask

  task automatic t_fence();
    push_one(32'hD001, 1, 3);
    push_one(32'hD002, 1, 3);
    push_one(32'hD003, 0, 5);
    push_one(32'hD004, 1, 5);
    check("R5", tag_busy, 8'b0010_1000);
    data_wr_req = 1; data_wr_tag = 3; #1;
    check("R6", {63'd0, data_wr_grant}, 0);
    data_wr_tag = 1; #1;
    check("R6", {63'd0, data_wr_grant}, 1);
    data_wr_req = 0; #1;
    check("R6", {63'd0, data_wr_grant}, 0);
    check("R2", {63'd0, pop_has_tag}, 1);
    check("R2", pop_tag, 3);
    pop_one("R5", 32'hD001);
    check("R5", tag_busy, 8'b0010_1000);
    pop_one("R5", 32'hD002);
    check("R5", tag_busy, 8'b0010_0000);
    data_wr_req = 1; data_wr_tag = 3; #1;
    check("R6", {63'd0, data_wr_grant}, 1);
    data_wr_req = 0;
    pop_one("R7", 32'hD003);
    check("R7", tag_busy, 8'b0010_0000);
    pop_one("R5", 32'hD004);
    check("R5", tag_busy, 0);
    push_one(32'hD005, 0, 6);
    check("R7", tag_busy, 0);
    pop_one("R7", 32'hD005);
  endtask

  task automatic t_same_cycle();
    push_one(32'hE001, 1, 2);
    push_valid = 1; push_cmd = 32'hE002; push_has_tag = 1; push_tag = 2;
    pop_ready = 1;
    check("R9", pop_cmd, 32'hE001);
    step();
    push_valid = 0; push_has_tag = 0; pop_ready = 0;
    check("R9", tag_busy, 8'b0000_0100);
    pop_one("R9", 32'hE002);
    check("R9", tag_busy, 0);
    check("R9", {63'd0, pop_valid}, 0);
  endtask

  task automatic t_drain();
    for (int i = 0; i < 3; i++) push_one(32'hF000 + i, 0, 0);
    drain_req = 1; #1;
    check("R8", {63'd0, push_ready}, 0);
    check("R8", {63'd0, drain_done}, 0);
    push_valid = 1; push_cmd = 32'hBAD0; step(); push_valid = 0;
    for (int i = 0; i < 3; i++) pop_one("R8", 32'hF000 + i);
    check("R8", {63'd0, drain_done}, 1);
    check("R8", {63'd0, pop_valid}, 0);
    drain_req = 0; #1;
    check("R8", {63'd0, push_ready}, 1);
    check("R8", {63'd0, drain_done}, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_order();
    t_full();
    t_empty();
    t_fence();
    t_same_cycle();
    t_drain();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule